// File: doc/BRIEF.md
# Serial Receive Error Status Logic

This block holds the receive-error flags for a serial port. The port runs either as an asynchronous UART or as a clocked synchronous link. Each time a frame is completed, the receiver core sends one strobe together with the frame's parity information and its bit count. The block checks that frame against the configured format and records parity, framing and overrun errors. It also keeps an error-sum flag. All four flags are presented in one status byte that is read alongside the receive data.

A small occupancy state machine follows the one-byte receive buffer. It has four states:

- OFF: receive disabled.
- EMPTY: no unread byte.
- FULL: one unread byte.
- OVERRUN: a frame was lost.

The state transitions are:

- OFF→EMPTY when receive-enable rises.
- Any state→OFF when receive-enable is low.
- EMPTY→FULL on a frame.
- EMPTY→OVERRUN on a frame that the core marks as an overrun.
- FULL→EMPTY on a lower-byte read.
- FULL→FULL on a frame arriving in the same cycle as a read.
- FULL→OVERRUN on a frame with no read, or on a frame with the overrun hint.
- OVERRUN holds until receive-enable drops.

While the OVERRUN state holds, a read cannot clear the parity flag or the error sum. Only dropping receive-enable clears them.

Top module: `rx_err_status`

## Requirements
- R1: After reset every flag is 0. Status bits 3..0 always read 0.
- R2: In UART mode with parity enabled, an accepted frame sets the parity flag (status bit 5) when `rx_data_xor ^ rx_par_bit ^ par_odd` is 1. Here `par_odd`=1 selects odd parity and `par_odd`=0 selects even parity. With parity disabled the flag is never set.
- R3: In UART mode, an accepted frame sets the framing flag (status bit 6) when `rx_bit_cnt` differs from `data_len + par_en`.
- R4: In clocked synchronous mode (`uart_mode`=0), status bits 5 and 6 read 0 and parity or length mismatches are ignored.
- R5: The overrun flag (status bit 4) is set in either mode in two cases: a frame completes while the previous byte is unread and no read occurs in that cycle, or a frame arrives with `ovr_hint`=1. Once set, it clears only when `rx_en` is 0.
- R6: With no overrun pending, a lower-byte read (`rd_lo`) clears the parity flag, the framing flag and the error sum.
- R7: While an overrun is pending, a read leaves the parity flag set but still clears the framing flag.
- R8: The error-sum flag (status bit 7) is 1 exactly when any error flag is held after an update. A read therefore cannot clear it while an overrun is pending.
- R9: When a flag's set condition and a clearing read fall in the same cycle, the flag becomes 1.
- R10: While `rx_en` is 0, all flags clear at the next clock edge and frames are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| uart_mode | input | 1 | 1 = asynchronous UART, 0 = clocked synchronous |
| par_en | input | 1 | Parity checking enabled |
| par_odd | input | 1 | 1 = odd parity, 0 = even parity |
| data_len | input | LEN_W | Configured data bits per frame |
| rx_en | input | 1 | Receive enable |
| frame_done | input | 1 | One-cycle strobe marking that a frame has completed |
| rx_data_xor | input | 1 | XOR of the received data bits |
| rx_par_bit | input | 1 | Received parity bit |
| rx_bit_cnt | input | LEN_W | Number of bits received before the stop bit |
| ovr_hint | input | 1 | Overrun indication from the receiver core |
| rd_lo | input | 1 | Strobe marking a read of the receive buffer's lower byte |
| status | output | 8 | {esum, framing, parity, overrun, 4'b0} |

## Verification
Frames are driven with correct parity, wrong parity under both even and odd selection, parity disabled, and a short bit count. These patterns separate the parity rule from the framing rule and confirm that the odd/even select reverses the outcome. The same bad frames are repeated in synchronous mode to show that the mode gate masks them, while overrun still works there. Overrun sequences insert reads between frames, which separates the overrun case where a read is blocked from the case where a read clears, and shows framing clearing while parity stays. A frame that coincides with a read, a frame carrying the overrun hint, and frames sent while receive is disabled cover the priority and disable rules.

// File: rtl/rx_err_pkg.sv
package rx_err_pkg;

    typedef enum logic [1:0] {
        OCC_OFF   = 2'd0,
        OCC_EMPTY = 2'd1,
        OCC_FULL  = 2'd2,
        OCC_OVR   = 2'd3
    } occ_state_t;

    localparam int STAT_W    = 8;
    localparam int BIT_OVR   = 4;
    localparam int BIT_PAR   = 5;
    localparam int BIT_FRM   = 6;
    localparam int BIT_ESUM  = 7;
    localparam int NUM_ERR   = 2;   // per-frame error kinds handled by flag bits
    localparam int IDX_PAR   = 0;
    localparam int IDX_FRM   = 1;

endpackage

// File: rtl/rx_frame_check.sv
module rx_frame_check #(
    parameter int LEN_W = 4
) (
    input  logic             par_en,
    input  logic             par_odd,
    input  logic [LEN_W-1:0] data_len,
    input  logic             rx_data_xor,
    input  logic             rx_par_bit,
    input  logic [LEN_W-1:0] rx_bit_cnt,
    output logic             par_mismatch,
    output logic             len_mismatch
);

    logic [LEN_W-1:0] expect_cnt;

    always_comb begin
        // even parity: data ones plus parity bit must be even
        par_mismatch = par_en & (rx_data_xor ^ rx_par_bit ^ par_odd);
        expect_cnt   = data_len + LEN_W'(par_en);
        len_mismatch = (rx_bit_cnt != expect_cnt);
    end

endmodule

// File: rtl/rx_occ_fsm.sv
module rx_occ_fsm
    import rx_err_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic rx_en,
    input  logic frame_done,
    input  logic ovr_hint,
    input  logic rd_lo,
    output logic accepting,
    output logic ovr_pending,
    output logic ovr_next
);

    occ_state_t state_q;
    occ_state_t state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= OCC_OFF;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        if (!rx_en) begin
            state_d = OCC_OFF;
        end else begin
            unique case (state_q)
                OCC_OFF: begin
                    state_d = OCC_EMPTY;
                end
                OCC_EMPTY: begin
                    if (frame_done) begin
                        state_d = ovr_hint ? OCC_OVR : OCC_FULL;
                    end
                end
                OCC_FULL: begin
                    if (frame_done) begin
                        state_d = (ovr_hint || !rd_lo) ? OCC_OVR : OCC_FULL;
                    end else if (rd_lo) begin
                        state_d = OCC_EMPTY;
                    end
                end
                OCC_OVR: begin
                    state_d = OCC_OVR;
                end
                default: begin
                    state_d = OCC_OFF;
                end
            endcase
        end
    end

    always_comb begin
        accepting   = (state_q != OCC_OFF);
        ovr_pending = (state_q == OCC_OVR);
        ovr_next    = (state_d == OCC_OVR);
    end

endmodule

// File: rtl/rx_err_bit.sv
module rx_err_bit #(
    parameter bit BLOCK_ON_OVR = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic set_evt,
    input  logic rd_lo,
    input  logic ovr_pending,
    output logic flag_q,
    output logic flag_d
);

    logic rd_clears;

    always_comb begin
        rd_clears = rd_lo & ~(BLOCK_ON_OVR & ovr_pending);
        if (!enable) begin
            flag_d = 1'b0;
        end else if (set_evt) begin
            flag_d = 1'b1;          // setting beats a same-cycle read
        end else if (rd_clears) begin
            flag_d = 1'b0;
        end else begin
            flag_d = flag_q;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flag_q <= 1'b0;
        end else begin
            flag_q <= flag_d;
        end
    end

endmodule

// File: rtl/rx_err_status.sv
module rx_err_status
    import rx_err_pkg::*;
#(
    parameter int LEN_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             uart_mode,
    input  logic             par_en,
    input  logic             par_odd,
    input  logic [LEN_W-1:0] data_len,
    input  logic             rx_en,
    input  logic             frame_done,
    input  logic             rx_data_xor,
    input  logic             rx_par_bit,
    input  logic [LEN_W-1:0] rx_bit_cnt,
    input  logic             ovr_hint,
    input  logic             rd_lo,
    output logic [7:0]       status
);

    logic               par_mismatch;
    logic               len_mismatch;
    logic               accepting;
    logic               ovr_pending;
    logic               ovr_next;
    logic               frame_ok;
    logic [NUM_ERR-1:0] err_set;
    logic [NUM_ERR-1:0] err_q;
    logic [NUM_ERR-1:0] err_d;
    logic               esum_q;

    rx_frame_check #(.LEN_W(LEN_W)) u_check (
        .par_en       (par_en),
        .par_odd      (par_odd),
        .data_len     (data_len),
        .rx_data_xor  (rx_data_xor),
        .rx_par_bit   (rx_par_bit),
        .rx_bit_cnt   (rx_bit_cnt),
        .par_mismatch (par_mismatch),
        .len_mismatch (len_mismatch)
    );

    rx_occ_fsm u_occ (
        .clk         (clk),
        .rst_n       (rst_n),
        .rx_en       (rx_en),
        .frame_done  (frame_done),
        .ovr_hint    (ovr_hint),
        .rd_lo       (rd_lo),
        .accepting   (accepting),
        .ovr_pending (ovr_pending),
        .ovr_next    (ovr_next)
    );

    always_comb begin
        frame_ok         = frame_done & rx_en & accepting;
        err_set[IDX_PAR] = frame_ok & par_mismatch;
        err_set[IDX_FRM] = frame_ok & len_mismatch;
    end

    for (genvar g = 0; g < NUM_ERR; g++) begin : g_err
        // parity stays through a read while overrun is pending; framing does not
        localparam bit BLOCK = (g == IDX_PAR);
        rx_err_bit #(.BLOCK_ON_OVR(BLOCK)) u_bit (
            .clk         (clk),
            .rst_n       (rst_n),
            .enable      (rx_en & uart_mode),
            .set_evt     (err_set[g]),
            .rd_lo       (rd_lo),
            .ovr_pending (ovr_pending),
            .flag_q      (err_q[g]),
            .flag_d      (err_d[g])
        );
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            esum_q <= 1'b0;
        end else begin
            esum_q <= ovr_next | (|err_d);
        end
    end

    always_comb begin
        status           = '0;
        status[BIT_OVR]  = ovr_pending;
        status[BIT_PAR]  = err_q[IDX_PAR];
        status[BIT_FRM]  = err_q[IDX_FRM];
        status[BIT_ESUM] = esum_q;
    end

endmodule

// File: rtl/rx_err_status_chk.sv
module rx_err_status_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       uart_mode,
    input logic       par_en,
    input logic       par_odd,
    input logic       rx_en,
    input logic       frame_done,
    input logic       rx_data_xor,
    input logic       rx_par_bit,
    input logic       rd_lo,
    input logic [7:0] status
);

    assert_low_nibble_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
        status[3:0] == 4'b0);

    assert_parity_set_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_done && rx_en && uart_mode && par_en && (rx_data_xor ^ rx_par_bit ^ par_odd)
         && status[4:0] == 5'b0 && rd_lo) |=> status[5]);

    assert_sync_masks_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!uart_mode && !$isunknown(status)) |=> status[6:5] == 2'b00);

    assert_overrun_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (status[4] && rx_en) |=> status[4]);

    assert_parity_held_in_ovr_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (status[4] && status[5] && rx_en && uart_mode) |=> status[5]);

    assert_esum_held_in_ovr_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (status[4] && rx_en) |=> status[7]);

    assert_disable_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_en |=> status == 8'h00);

endmodule

bind rx_err_status rx_err_status_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .uart_mode   (uart_mode),
    .par_en      (par_en),
    .par_odd     (par_odd),
    .rx_en       (rx_en),
    .frame_done  (frame_done),
    .rx_data_xor (rx_data_xor),
    .rx_par_bit  (rx_par_bit),
    .rd_lo       (rd_lo),
    .status      (status)
);

// File: tb/rx_err_status_bench.sv
`timescale 1ns/1ps
module rx_err_status_bench;

    localparam int LEN_W = 4;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             uart_mode = 1'b1;
    logic             par_en = 1'b1;
    logic             par_odd = 1'b0;
    logic [LEN_W-1:0] data_len = 4'd8;
    logic             rx_en = 1'b0;
    logic             frame_done = 1'b0;
    logic             rx_data_xor = 1'b0;
    logic             rx_par_bit = 1'b0;
    logic [LEN_W-1:0] rx_bit_cnt = 4'd9;
    logic             ovr_hint = 1'b0;
    logic             rd_lo = 1'b0;
    logic [7:0]       status;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    rx_err_status #(.LEN_W(LEN_W)) u_rx_err_status (
        .clk         (clk),
        .rst_n       (rst_n),
        .uart_mode   (uart_mode),
        .par_en      (par_en),
        .par_odd     (par_odd),
        .data_len    (data_len),
        .rx_en       (rx_en),
        .frame_done  (frame_done),
        .rx_data_xor (rx_data_xor),
        .rx_par_bit  (rx_par_bit),
        .rx_bit_cnt  (rx_bit_cnt),
        .ovr_hint    (ovr_hint),
        .rd_lo       (rd_lo),
        .status      (status)
    );

    task automatic check(input string req, input logic [7:0] exp);
        checks++;
        if (status !== exp) begin
            failures++;
            $display("FAIL %s status=%02h expected=%02h", req, status, exp);
        end
    endtask

    // called at a negedge; applies strobes for one edge, returns at next negedge
    task automatic step(input logic frm, input logic x, input logic p,
                        input logic [LEN_W-1:0] cnt, input logic hint, input logic rd);
        frame_done  = frm;
        rx_data_xor = x;
        rx_par_bit  = p;
        rx_bit_cnt  = cnt;
        ovr_hint    = hint;
        rd_lo       = rd;
        @(posedge clk);
        @(negedge clk);
        frame_done = 1'b0;
        ovr_hint   = 1'b0;
        rd_lo      = 1'b0;
    endtask

    task automatic read_lo();
        step(1'b0, 1'b0, 1'b0, 4'd9, 1'b0, 1'b1);
    endtask

    task automatic set_en(input logic v);
        rx_en = v;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic t_reset();
        check("R1 reset", 8'h00);
        set_en(1'b1);
        check("R1 after enable", 8'h00);
    endtask

    task automatic t_parity();
        // even parity, 8 data + parity = 9 bits
        step(1'b1, 1'b0, 1'b0, 4'd9, 1'b0, 1'b0);
        check("R2 good even frame", 8'h00);
        read_lo();
        step(1'b1, 1'b1, 1'b0, 4'd9, 1'b0, 1'b0);
        check("R2 bad even parity", 8'hA0);
        read_lo();
        check("R6 read clears parity", 8'h00);
        par_odd = 1'b1;
        step(1'b1, 1'b1, 1'b0, 4'd9, 1'b0, 1'b0);
        check("R2 good odd frame", 8'h00);
        read_lo();
        step(1'b1, 1'b0, 1'b0, 4'd9, 1'b0, 1'b0);
        check("R2 bad odd parity", 8'hA0);
        read_lo();
        par_odd = 1'b0;
        par_en  = 1'b0;
        step(1'b1, 1'b1, 1'b0, 4'd8, 1'b0, 1'b0);
        check("R2 parity disabled ignores mismatch", 8'h00);
        read_lo();
        par_en = 1'b1;
    endtask

    task automatic t_framing();
        step(1'b1, 1'b0, 1'b0, 4'd7, 1'b0, 1'b0);
        check("R3 short frame", 8'hC0);
        read_lo();
        check("R6 R8 read clears framing and esum", 8'h00);
    endtask

    task automatic t_sync();
        uart_mode = 1'b0;
        step(1'b1, 1'b1, 1'b0, 4'd5, 1'b0, 1'b0);
        check("R4 sync ignores parity and length", 8'h00);
        step(1'b1, 1'b0, 1'b0, 4'd9, 1'b0, 1'b0);
        check("R4 R5 overrun in sync mode", 8'h90);
        set_en(1'b0);
        check("R10 disable clears sync overrun", 8'h00);
        uart_mode = 1'b1;
        set_en(1'b1);
    endtask

    task automatic t_overrun();
        step(1'b1, 1'b1, 1'b0, 4'd9, 1'b0, 1'b0);
        check("R2 bad parity before overrun", 8'hA0);
        step(1'b1, 1'b0, 1'b0, 4'd9, 1'b0, 1'b0);
        check("R5 second frame without read", 8'hB0);
        read_lo();
        check("R7 R8 read blocked during overrun", 8'hB0);
        step(1'b1, 1'b0, 1'b0, 4'd7, 1'b0, 1'b0);
        check("R3 framing during overrun", 8'hF0);
        read_lo();
        check("R7 read clears framing only", 8'hB0);
        set_en(1'b0);
        check("R10 disable clears overrun", 8'h00);
        set_en(1'b1);
    endtask

    task automatic t_set_wins();
        step(1'b1, 1'b1, 1'b0, 4'd9, 1'b0, 1'b1);
        check("R9 set beats same-cycle read", 8'hA0);
        read_lo();
        check("R6 later read clears", 8'h00);
    endtask

    task automatic t_hint_disable();
        step(1'b1, 1'b0, 1'b0, 4'd9, 1'b1, 1'b0);
        check("R5 core overrun hint", 8'h90);
        read_lo();
        check("R5 read keeps overrun", 8'h90);
        set_en(1'b0);
        check("R10 disable clears", 8'h00);
        step(1'b1, 1'b1, 1'b0, 4'd3, 1'b0, 1'b0);
        check("R10 frames ignored while disabled", 8'h00);
        set_en(1'b1);
        check("R1 re-enabled idle", 8'h00);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_parity();
        t_framing();
        t_sync();
        t_overrun();
        t_set_wins();
        t_hint_disable();
        done = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule